// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and chooses which one a CPU services next. Each line latches a pending flag on its rising edge. The lines share their priority settings in six groups of three: group g holds sources g, g+6 and g+12. Firmware gives each group one of four levels through a small write-only configuration port, which also holds one enable bit per source and a global enable.

The controller shows the CPU a request together with the number of the winning source. When the CPU acknowledges, the source's pending flag clears and its level is marked as in service. Only a strictly higher level can interrupt a service that is running. A return-from-interrupt pulse closes the highest level in service, and anything held back is then presented.

While the device sleeps, a fixed subset of sources raises a wake request to the power manager. The other sources stay pending quietly until the CPU is running again.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A source becomes pending on the clock edge that sees its line go from 0 to 1. `cpu_req` reflects it one cycle later. A line held high does not set the flag again after it has been cleared.
- R2: `cpu_vec` names the enabled pending source of highest level. The level of source s is the level of group s mod 6.
- R3: Among enabled pending sources of equal level, the lowest source number wins.
- R4: `cpu_ack` while `cpu_req` is high clears the pending flag of the presented source and marks its level as in service. `cpu_ack` while `cpu_req` is low has no effect.
- R5: While any level is in service, a request is presented only if the winner's level is strictly above the highest level in service. `cpu_reti` removes only the highest level in service.
- R6: If a new edge on a source arrives in the same cycle as the acknowledge of that source, the source stays pending.
- R7: With the global enable at 0, `cpu_req` stays low and pending flags are kept. Setting the enable back to 1 presents them.
- R8: A source whose enable bit is 0 is neither presented nor able to wake, but its pending flag is kept.
- R9: `wake_req` is high exactly when `sleep_mode` is high and an enabled, pending, wake-capable source exists. The default wake-capable sources are 2, 8 and 15. Other sources pending during sleep leave `wake_req` low.
- R10: A write with `cfg_addr` 0 to 5 sets the level of that group from `cfg_wdata[1:0]`. Address 6 loads the source enables from `cfg_wdata[17:0]`, and address 7 loads the global enable from `cfg_wdata[0]`.
- R11: After reset, no source is pending, nothing is in service, all levels are 0, all enables are 0, and `cpu_req` and `wake_req` are low.
- R12: `cpu_reti` with nothing in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 18 | Interrupt request lines, edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 18 | Configuration write data |
| cpu_ack | input | 1 | CPU takes the presented vector |
| cpu_reti | input | 1 | CPU returns from the current service |
| sleep_mode | input | 1 | Device is in a sleep mode |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_vec | output | 5 | Number of the presented source |
| wake_req | output | 1 | Wake request to the power manager |

## Verification
Two events can land on one source in the same cycle: the acknowledge that clears its pending flag, and a fresh rising edge on its line that sets the flag again. The bench presents source 4, releases the line for a cycle, then raises it again exactly as the acknowledge is given. It then expects the request to stay low while level 1 is in service, and source 4 to be presented again after the return pulse. A design that let the clear win would show no request at that point. A second overlap, where a preempting request arrives during a lower-level service, is judged by the vector presented before and after each return pulse.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  localparam int unsigned SRC_COUNT  = 18;
  localparam int unsigned GROUP_COUNT = 6;
  localparam int unsigned LEVEL_BITS = 2;

  // sources g, g+G, g+2G ... share group g
  function automatic int unsigned group_of(input int unsigned src, input int unsigned ngrp);
    return src % ngrp;
  endfunction

  // configuration address of the source-enable register
  function automatic int unsigned enable_addr(input int unsigned ngrp);
    return ngrp;
  endfunction

  // configuration address of the global-enable register
  function automatic int unsigned global_addr(input int unsigned ngrp);
    return ngrp + 1;
  endfunction

endpackage

// File: rtl/grp_irq_cfg.sv
module grp_irq_cfg #(
  parameter int unsigned NSRC   = grp_irq_pkg::SRC_COUNT,
  parameter int unsigned NGRP   = grp_irq_pkg::GROUP_COUNT,
  parameter int unsigned LVL_W  = grp_irq_pkg::LEVEL_BITS,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [NSRC-1:0]            cfg_wdata,
  output logic [NGRP-1:0][LVL_W-1:0] grp_lvl,
  output logic [NSRC-1:0]            src_en,
  output logic                       glb_en
);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(grp_irq_pkg::enable_addr(NGRP));
  localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(grp_irq_pkg::global_addr(NGRP));

  for (genvar g = 0; g < NGRP; g++) begin : g_lvl
    logic hit;
    assign hit = cfg_we && (cfg_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   grp_lvl[g] <= '0;
      else if (hit) grp_lvl[g] <= cfg_wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en <= '0;
      glb_en <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == EN_ADDR)  src_en <= cfg_wdata;
      if (cfg_addr == GLB_ADDR) glb_en <= cfg_wdata[0];
    end
  end

  // R10
  glb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == GLB_ADDR |=> glb_en == $past(cfg_wdata[0]));

endmodule

// File: rtl/grp_irq_pend.sv
module grp_irq_pend #(
  parameter int unsigned NSRC  = grp_irq_pkg::SRC_COUNT,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= irq_req;
  end

  assign edge_hit = irq_req & ~req_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic clr_hit;
    assign clr_hit = clr_en && (clr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend[i] <= 1'b0;
      else if (edge_hit[i]) pend[i] <= 1'b1;
      else if (clr_hit)     pend[i] <= 1'b0;
    end

    // R1
    rise_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(edge_hit[i]));

    // R6
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> pend[i]);

    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit && !edge_hit[i] |=> !pend[i]);
  end

endmodule

// File: rtl/grp_irq_arb.sv
module grp_irq_arb #(
  parameter int unsigned NSRC  = grp_irq_pkg::SRC_COUNT,
  parameter int unsigned NGRP  = grp_irq_pkg::GROUP_COUNT,
  parameter int unsigned LVL_W = grp_irq_pkg::LEVEL_BITS,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            cand,
  input  logic [NGRP-1:0][LVL_W-1:0] grp_lvl,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx,
  output logic [LVL_W-1:0]           win_lvl
);
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    assign src_lvl[s] = grp_lvl[grp_irq_pkg::group_of(s, NGRP)];
  end

  // scan downward; ">=" lets a lower index take over a tie
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (cand[s] && (!win_valid || src_lvl[s] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(s);
        win_lvl   = src_lvl[s];
      end
    end
  end

endmodule

// File: rtl/grp_irq_svc.sv
module grp_irq_svc #(
  parameter int unsigned LVL_W = grp_irq_pkg::LEVEL_BITS,
  parameter int unsigned NLVL  = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_ack,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic             reti,
  output logic             act_any,
  output logic [LVL_W-1:0] act_lvl
);
  logic [NLVL-1:0] isr_q;
  logic [NLVL-1:0] isr_d;

  always_comb begin
    act_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) act_lvl = LVL_W'(l);
    end
  end

  assign act_any = |isr_q;

  always_comb begin
    isr_d = isr_q;
    if (reti && act_any) isr_d[act_lvl] = 1'b0;
    if (do_ack)          isr_d[ack_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  // R4
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_ack |=> act_any && act_lvl >= $past(ack_lvl));

  // R12
  idle_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !act_any && !do_ack |=> !act_any);

  // R5
  reti_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti && act_any && !do_ack |=> !act_any || act_lvl < $past(act_lvl));

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int unsigned     NSRC      = grp_irq_pkg::SRC_COUNT,
  parameter int unsigned     NGRP      = grp_irq_pkg::GROUP_COUNT,
  parameter int unsigned     LVL_W     = grp_irq_pkg::LEVEL_BITS,
  parameter logic [NSRC-1:0] WAKE_MASK = 18'h08104
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            irq_req,
  input  logic                       cfg_we,
  input  logic [$clog2(NGRP+2)-1:0]  cfg_addr,
  input  logic [NSRC-1:0]            cfg_wdata,
  input  logic                       cpu_ack,
  input  logic                       cpu_reti,
  input  logic                       sleep_mode,
  output logic                       cpu_req,
  output logic [$clog2(NSRC)-1:0]    cpu_vec,
  output logic                       wake_req
);
  localparam int unsigned IDX_W  = $clog2(NSRC);
  localparam int unsigned ADDR_W = $clog2(NGRP + 2);
  localparam int unsigned NLVL   = 1 << LVL_W;

  logic [NGRP-1:0][LVL_W-1:0] grp_lvl;
  logic [NSRC-1:0]            src_en;
  logic                       glb_en;
  logic [NSRC-1:0]            pend;
  logic [NSRC-1:0]            cand;
  logic [NSRC-1:0]            wake_hits;
  logic                       win_valid;
  logic [IDX_W-1:0]           win_idx;
  logic [LVL_W-1:0]           win_lvl;
  logic                       act_any;
  logic [LVL_W-1:0]           act_lvl;
  logic                       preempt_ok;
  logic                       do_ack;

  grp_irq_cfg #(.NSRC(NSRC), .NGRP(NGRP), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .grp_lvl(grp_lvl), .src_en(src_en), .glb_en(glb_en)
  );

  grp_irq_pend #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .clr_en(do_ack), .clr_idx(win_idx), .pend(pend)
  );

  assign cand = pend & src_en & {NSRC{glb_en}};

  grp_irq_arb #(.NSRC(NSRC), .NGRP(NGRP), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .cand(cand), .grp_lvl(grp_lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  grp_irq_svc #(.LVL_W(LVL_W), .NLVL(NLVL)) u_svc (
    .clk(clk), .rst_n(rst_n), .do_ack(do_ack), .ack_lvl(win_lvl),
    .reti(cpu_reti), .act_any(act_any), .act_lvl(act_lvl)
  );

  assign preempt_ok = !act_any || (win_lvl > act_lvl);
  assign cpu_req    = win_valid && preempt_ok;
  assign cpu_vec    = win_idx;
  assign do_ack     = cpu_ack && cpu_req;

  assign wake_hits  = pend & src_en & WAKE_MASK;
  assign wake_req   = sleep_mode && (|wake_hits);

  // R2
  vec_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> pend[cpu_vec] && src_en[cpu_vec]);

  // R7
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !cpu_req);

  // R9
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleep_mode && (|(pend & WAKE_MASK)));

  // R5
  no_same_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && act_any |-> win_lvl != act_lvl);

endmodule

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [17:0] cfg_wdata = '0;
  logic        cpu_ack = 1'b0;
  logic        cpu_reti = 1'b0;
  logic        sleep_mode = 1'b0;
  logic        cpu_req;
  logic [4:0]  cpu_vec;
  logic        wake_req;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  grp_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cpu_ack(cpu_ack),
    .cpu_reti(cpu_reti), .sleep_mode(sleep_mode), .cpu_req(cpu_req),
    .cpu_vec(cpu_vec), .wake_req(wake_req)
  );

  // {irq[17:0], ack, reti, sleep, exp_req, exp_vec[4:0], exp_wake}
  // group levels: g0=1 g1=0 g2=2 g3=3 g4=1 g5=0, level(s) = level(s mod 6)
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {18'h00001, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  1'b0},
    {18'h00040, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00008, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd6,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h02082, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd7,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd13, 1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00002, 1'b0, 1'b0, 1'b1, 1'b1, 5'd1,  1'b0},
    {18'h00100, 1'b0, 1'b0, 1'b1, 1'b1, 5'd8,  1'b1},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00010, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4,  1'b0},
    {18'h00000, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4,  1'b0},
    {18'h00010, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b1, 5'd4,  1'b0},
    {18'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},
    {18'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0:              return "R1";
      1, 9, 11, 13:   return "R3";
      2, 4, 7, 10:    return "R4";
      3, 5, 6, 8:     return "R5";
      16, 17, 18:     return "R9";
      24, 25:         return "R6";
      default:        return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic er, input logic [4:0] ev, input logic ew);
    nchk++;
    if (cpu_req !== er || (er && cpu_vec !== ev) || wake_req !== ew) begin
      nfail++;
      $display("FAIL %s: req=%0b vec=%0d wake=%0b, expected req=%0b vec=%0d wake=%0b",
               tag, cpu_req, cpu_vec, wake_req, er, ev, ew);
    end
  endtask

  // inputs change at a falling edge, one rising edge passes, state is read at the next fall
  task automatic step(input logic [17:0] irq, input logic ack, input logic reti, input logic slp);
    irq_req = irq; cpu_ack = ack; cpu_reti = reti; sleep_mode = slp;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [17:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R11: outputs quiet in and just after reset
    chk("R11", 1'b0, 5'd0, 1'b0);
    rst_n = 1'b1;
    step(18'h00001, 1'b0, 1'b0, 1'b1);
    chk("R11", 1'b0, 5'd0, 1'b0);   // enables still 0 after reset
    step(18'h00000, 1'b0, 1'b0, 1'b0);

    // R10: program levels and enables
    cfg_write(3'd0, 18'd1);
    cfg_write(3'd1, 18'd0);
    cfg_write(3'd2, 18'd2);
    cfg_write(3'd3, 18'd3);
    cfg_write(3'd4, 18'd1);
    cfg_write(3'd5, 18'd0);
    cfg_write(3'd6, 18'h3FFFF);
    cfg_write(3'd7, 18'd1);
    // source 0 pended before enables were set: presented now (R8)
    chk("R8", 1'b1, 5'd0, 1'b0);
    step(18'h00000, 1'b1, 1'b0, 1'b0);
    step(18'h00000, 1'b0, 1'b1, 1'b0);
    chk("R10", 1'b0, 5'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27:10], VEC[i][9], VEC[i][8], VEC[i][7]);
      chk(row_tag(i), VEC[i][6], VEC[i][5:1], VEC[i][0]);
    end

    // R7: global enable off holds pending source 9
    cfg_write(3'd7, 18'd0);
    step(18'h00200, 1'b0, 1'b0, 1'b0);
    chk("R7", 1'b0, 5'd0, 1'b0);
    step(18'h00000, 1'b1, 1'b0, 1'b0);   // ack with no request is ignored
    chk("R7", 1'b0, 5'd0, 1'b0);
    cfg_write(3'd7, 18'd1);
    chk("R7", 1'b1, 5'd9, 1'b0);
    step(18'h00000, 1'b1, 1'b0, 1'b0);
    step(18'h00000, 1'b0, 1'b1, 1'b0);
    chk("R4", 1'b0, 5'd0, 1'b0);

    // R8: disabled wake-capable source 2 neither requests nor wakes
    cfg_write(3'd6, 18'h3FFFB);
    step(18'h00004, 1'b0, 1'b0, 1'b1);
    chk("R8", 1'b0, 5'd0, 1'b0);
    step(18'h00000, 1'b0, 1'b0, 1'b1);
    cfg_write(3'd6, 18'h3FFFF);
    chk("R9", 1'b1, 5'd2, 1'b1);
    step(18'h00000, 1'b1, 1'b0, 1'b0);
    chk("R9", 1'b0, 5'd0, 1'b0);
    step(18'h00000, 1'b0, 1'b1, 1'b0);

    // R10: group 5 raised to level 3, tie with source 3
    cfg_write(3'd5, 18'd3);
    step(18'h00028, 1'b0, 1'b0, 1'b0);
    chk("R3", 1'b1, 5'd3, 1'b0);
    step(18'h00000, 1'b1, 1'b0, 1'b0);
    chk("R5", 1'b0, 5'd0, 1'b0);
    step(18'h00000, 1'b0, 1'b1, 1'b0);
    chk("R10", 1'b1, 5'd5, 1'b0);
    step(18'h00000, 1'b1, 1'b0, 1'b0);
    step(18'h00000, 1'b0, 1'b1, 1'b0);
    chk("R10", 1'b0, 5'd0, 1'b0);

    // R12: return with nothing in service, then a level-0 source still gets in
    step(18'h00000, 1'b0, 1'b1, 1'b0);
    step(18'h00002, 1'b0, 1'b0, 1'b0);
    chk("R12", 1'b1, 5'd1, 1'b0);
    // R1: line held high through the acknowledge does not re-pend
    step(18'h00002, 1'b1, 1'b0, 1'b0);
    chk("R1", 1'b0, 5'd0, 1'b0);
    step(18'h00002, 1'b0, 1'b1, 1'b0);
    chk("R1", 1'b0, 5'd0, 1'b0);
    step(18'h00000, 1'b0, 1'b0, 1'b0);
    chk("R1", 1'b0, 5'd0, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule